// File: doc/BRIEF.md
# Indirect Configuration Bus Bridge

This block lets a controller reach a host-side plug-and-play configuration space through a two-level indirect path. The controller first runs one bus cycle that writes a register index to the index port. It then runs a second cycle that writes or reads a byte through the data port. Each cycle is a single byte, and the controller starts it by writing a go command. The bridge then drives a request on an internal configuration bus and holds it until the slave acknowledges it or a timeout expires.

The controller sees four byte-wide registers:

| Address | Register | Contents |
|---|---|---|
| 0 | Port selector | One bit: 0 selects the index port, 1 selects the data port |
| 1 | Data | The byte to send, or the byte returned by a read |
| 2 | Gate | One bit that must be set before any cycle can start |
| 3 | Command/status | The go and read bits when written; the busy flags and error bit when read |

Separate read-busy and write-busy flags let firmware poll for completion. A power-good input gates every access. Requests that cannot be honoured raise a sticky error bit, which firmware clears by writing 1 to it.

The configuration register file behind the bus is not part of this block. Host-side decoding and firmware retry policy are also outside it.

Top module: `ibb_bridge`

## Requirements
- R1: After reset every register reads 0 and `cfgReq` is low.
- R2: Writing address 3 with bit 0 = 1 and bit 1 = 0 starts a write cycle when power is good, the gate bit is 1 and no cycle is active. On the next clock `cfgReq` and `cfgWrite` are 1, and status bit 2 (write-busy) and bit 0 (any-busy) read 1.
- R3: Writing address 3 with bits 1:0 = 11 starts a read cycle, and status bit 1 (read-busy) reads 1. When the slave acknowledges, `cfgRdata` is stored into the data register at address 1.
- R4: On the clock edge that samples `cfgAck` high with a cycle active, the cycle ends. One cycle after that edge, `cfgReq` and both busy flags are 0.
- R5: A go command is ignored while the gate bit (address 2, bit 0) is 0. No cycle starts and the error bit is unchanged.
- R6: A go command while `pwrGood` is low starts no cycle and sets the error bit (status bit 3).
- R7: A go command while a cycle is active is ignored: the active cycle and its operands continue unchanged. The error bit is set.
- R8: If a cycle has had `cfgReq` high for TIMEOUT (default 64) clocks without an acknowledge, it is aborted. `cfgReq` and the busy flags clear and the error bit is set.
- R9: Writing address 3 with bit 3 = 1 clears the error bit; writing bit 3 = 0 leaves it. A new error event in the same clock wins over the clear.
- R10: `cfgPort` and `cfgWdata` take the port selector and data register values at the go command. They hold those values for the whole cycle, even if the registers are rewritten meanwhile.
- R11: Addresses 0 and 2 read back only their bit 0; all other bits read 0. Status bits above bit 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrGood | input | 1 | Main supply on; gates every cycle start |
| regWe | input | 1 | Controller register write strobe |
| regAddr | input | 2 | Controller register address |
| regWdata | input | DATA_W | Controller write data |
| regRdata | output | DATA_W | Controller read data for regAddr |
| cfgReq | output | 1 | Bus request, high for the whole cycle |
| cfgWrite | output | 1 | 1 for a write cycle, 0 for a read |
| cfgPort | output | 1 | Target port: 0 index, 1 data |
| cfgWdata | output | DATA_W | Byte driven on a write cycle |
| cfgAck | input | 1 | Slave acknowledge |
| cfgRdata | input | DATA_W | Byte returned on a read cycle |

## Verification
If a busy flag or the timeout counter is corrupted, the fault shows at the ports one clock later. `cfgReq` either stays up past an acknowledge or drops before one, and the status byte read at address 3 disagrees with the model on that same cycle.

If the captured operands go wrong, `cfgPort` or `cfgWdata` moves while a cycle is still in flight. If the read latch goes wrong, address 1 returns the wrong byte on the cycle after the acknowledge.

An error bit that fails to set after a power-off, colliding or expired command stays hidden until status is next read. The reference model therefore sweeps every register address on idle cycles.

// File: rtl/ibb_pkg.sv
package ibb_pkg;

  typedef enum logic [1:0] {
    REG_PORT   = 2'd0,
    REG_DATA   = 2'd1,
    REG_GATE   = 2'd2,
    REG_CMD    = 2'd3
  } regSel_e;

  // Command / status bit positions (firmware decodes these)
  localparam int CMD_GO     = 0;  // write: launch; read: any busy
  localparam int CMD_RD     = 1;  // write: read action; read: read-busy
  localparam int STS_WRBUSY = 2;  // read: write-busy
  localparam int STS_ERR    = 3;  // read: sticky error; write 1: clear

  typedef struct packed {
    logic launch;
    logic latchRead;
  } ctrlStrobe_t;

  typedef struct packed {
    logic rdBusy;
    logic wrBusy;
    logic err;
  } ctrlStatus_t;

endpackage

// File: rtl/ibb_ctrl.sv
module ibb_ctrl
  import ibb_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              gateEn,
  input  logic              cfgAck,
  output ctrlStrobe_t       strobe,
  output ctrlStatus_t       status,
  output logic              cfgReq,
  output logic              cfgWrite
);

  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(TIMEOUT - 1);

  logic             rdBusy, wrBusy, errFlag;
  logic [CNT_W-1:0] waitCnt;
  logic             cmdWrite, goReq, readSel, errClr;
  logic             anyBusy, launchOk, collide, ackSeen, expire, finish;

  assign cmdWrite = regWe && (regAddr == REG_CMD);
  assign goReq    = cmdWrite && regWdata[CMD_GO];
  assign readSel  = regWdata[CMD_RD];
  assign errClr   = cmdWrite && regWdata[STS_ERR];
  assign anyBusy  = rdBusy | wrBusy;
  assign launchOk = goReq && !anyBusy && gateEn && pwrGood;
  assign collide  = goReq && (anyBusy || !pwrGood);
  assign ackSeen  = anyBusy && cfgAck;
  assign expire   = anyBusy && !cfgAck && (waitCnt == LAST_WAIT);
  assign finish   = ackSeen || expire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBusy <= 1'b0;
      wrBusy <= 1'b0;
    end else if (launchOk) begin
      rdBusy <= readSel;
      wrBusy <= !readSel;
    end else if (finish) begin
      rdBusy <= 1'b0;
      wrBusy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 waitCnt <= '0;
    else if (launchOk || finish) waitCnt <= '0;
    else if (anyBusy)          waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  errFlag <= 1'b0;
    else if (collide || expire) errFlag <= 1'b1;
    else if (errClr)            errFlag <= 1'b0;
  end

  always_comb begin
    strobe.launch    = launchOk;
    strobe.latchRead = ackSeen && rdBusy;
    status.rdBusy    = rdBusy;
    status.wrBusy    = wrBusy;
    status.err       = errFlag;
  end

  assign cfgReq   = anyBusy;
  assign cfgWrite = wrBusy;

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdBusy && wrBusy));                                                // R2
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (goReq && !gateEn && !anyBusy) |=> !anyBusy);                        // R5
  AST_NO_POWER_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (goReq && !pwrGood && !anyBusy) |=> (!anyBusy && errFlag));          // R6
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (anyBusy && cfgAck) |=> !anyBusy);                                   // R4
  AST_COLLIDE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (goReq && anyBusy && !cfgAck) |=> (errFlag && anyBusy));             // R7
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (waitCnt <= LAST_WAIT));                                             // R8
  AST_EXPIRE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (anyBusy && !cfgAck && waitCnt == LAST_WAIT) |=> (errFlag && !anyBusy)); // R8

endmodule

// File: rtl/ibb_dpath.sv
module ibb_dpath
  import ibb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  ctrlStrobe_t       strobe,
  input  ctrlStatus_t       status,
  input  logic [DATA_W-1:0] cfgRdata,
  output logic              gateEn,
  output logic              cfgPort,
  output logic [DATA_W-1:0] cfgWdata
);

  logic              portSel;
  logic [DATA_W-1:0] dataReg;
  logic              gateReg;
  logic              busPort;
  logic [DATA_W-1:0] busWdata;
  logic              busyIn;

  assign busyIn = status.rdBusy | status.wrBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portSel <= 1'b0;
      gateReg <= 1'b0;
    end else if (regWe) begin
      if (regAddr == REG_PORT) portSel <= regWdata[0];
      if (regAddr == REG_GATE) gateReg <= regWdata[0];
    end
  end

  // returned read byte has priority over a firmware write in the same clock
  always_ff @(posedge clk) begin
    if (!rstN)                                  dataReg <= '0;
    else if (strobe.latchRead)                  dataReg <= cfgRdata;
    else if (regWe && regAddr == REG_DATA)      dataReg <= regWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busPort  <= 1'b0;
      busWdata <= '0;
    end else if (strobe.launch) begin
      busPort  <= portSel;
      busWdata <= dataReg;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      REG_PORT: regRdata[0] = portSel;
      REG_DATA: regRdata    = dataReg;
      REG_GATE: regRdata[0] = gateReg;
      REG_CMD: begin
        regRdata[CMD_GO]     = busyIn;
        regRdata[CMD_RD]     = status.rdBusy;
        regRdata[STS_WRBUSY] = status.wrBusy;
        regRdata[STS_ERR]    = status.err;
      end
      default: regRdata = '0;
    endcase
  end

  assign gateEn   = gateReg;
  assign cfgPort  = busPort;
  assign cfgWdata = busWdata;

  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && $past(busyIn)) |-> ($stable(busPort) && $stable(busWdata))); // R10
  AST_READ_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchRead |=> (dataReg == $past(cfgRdata)));                    // R3

endmodule

// File: rtl/ibb_bridge.sv
module ibb_bridge
  import ibb_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              cfgReq,
  output logic              cfgWrite,
  output logic              cfgPort,
  output logic [DATA_W-1:0] cfgWdata,
  input  logic              cfgAck,
  input  logic [DATA_W-1:0] cfgRdata
);

  ctrlStrobe_t strobe;
  ctrlStatus_t status;
  logic        gateEn;

  ibb_ctrl #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pwrGood  (pwrGood),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .gateEn   (gateEn),
    .cfgAck   (cfgAck),
    .strobe   (strobe),
    .status   (status),
    .cfgReq   (cfgReq),
    .cfgWrite (cfgWrite)
  );

  ibb_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .strobe   (strobe),
    .status   (status),
    .cfgRdata (cfgRdata),
    .gateEn   (gateEn),
    .cfgPort  (cfgPort),
    .cfgWdata (cfgWdata)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rstN |=> !cfgReq);                                                  // R1

endmodule

// File: tb/sim_ibb_bridge.sv
`timescale 1ns/100ps
module sim_ibb_bridge;
  localparam int DW = 8;
  localparam int TO = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pwrGood = 1'b1;
  logic          regWe = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic          cfgReq, cfgWrite, cfgPort;
  logic [DW-1:0] cfgWdata;
  logic          cfgAck = 1'b0;
  logic [DW-1:0] cfgRdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int rot = 0;
  string curReq = "R1";

  // behavioural reference state
  int mPsel = 0, mData = 0, mEn = 0, mErr = 0, mBusy = 0, mCnt = 0, mPort = 0, mWd = 0;

  always #2.5 clk = ~clk;

  ibb_bridge #(.DATA_W(DW), .TIMEOUT(TO)) u0 (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cfgReq(cfgReq), .cfgWrite(cfgWrite),
    .cfgPort(cfgPort), .cfgWdata(cfgWdata), .cfgAck(cfgAck), .cfgRdata(cfgRdata)
  );

  always @(posedge clk) begin
    int oldBusy;
    bit go;
    if (!rstN) begin
      mPsel = 0; mData = 0; mEn = 0; mErr = 0; mBusy = 0; mCnt = 0; mPort = 0; mWd = 0;
    end else begin
      oldBusy = mBusy;
      go = regWe && regAddr == 2'd3 && regWdata[0];
      if (regWe && regAddr == 2'd3 && regWdata[3]) mErr = 0;
      if (regWe && regAddr == 2'd0) mPsel = regWdata[0];
      if (regWe && regAddr == 2'd1) mData = regWdata;
      if (regWe && regAddr == 2'd2) mEn = regWdata[0];
      if (oldBusy != 0) begin
        if (cfgAck) begin
          if (oldBusy == 1) mData = cfgRdata;
          mBusy = 0;
        end else if (mCnt == TO - 1) begin
          mBusy = 0; mErr = 1;
        end else mCnt = mCnt + 1;
      end
      if (go) begin
        if (!pwrGood || oldBusy != 0) mErr = 1;
        else if (mEn != 0) begin
          mBusy = regWdata[1] ? 1 : 2;
          mPort = mPsel; mWd = mData; mCnt = 0;
        end
      end
    end
  end

  function automatic int expRd(input int a);
    case (a)
      0: return mPsel;
      1: return mData;
      2: return mEn;
      default: return (mBusy != 0 ? 1 : 0) | (mBusy == 1 ? 2 : 0) |
                      (mBusy == 2 ? 4 : 0) | (mErr << 3);
    endcase
  endfunction

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("cfgReq", cfgReq, mBusy != 0);
      check("regRdata", regRdata, expRd(regAddr));
      if (mBusy != 0) begin
        check("cfgWrite", cfgWrite, mBusy == 2);
        check("cfgPort", cfgPort, mPort);
        check("cfgWdata", cfgWdata, mWd);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      regWe = 1'b0; cfgAck = 1'b0;
      regAddr = 2'(rot); rot++;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    regWe = 1'b1; regAddr = 2'(a); regWdata = DW'(d); cfgAck = 1'b0;
  endtask

  task automatic ack(input int rd);
    @(negedge clk); #1;
    regWe = 1'b0; cfgAck = 1'b1; cfgRdata = DW'(rd); regAddr = 2'd3;
  endtask

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    for (int a = 0; a < 4; a++) begin
      regAddr = 2'(a); #0.1;
      check("reset read", regRdata, 0);
    end
    check("reset req", cfgReq, 0);
    #1 rstN = 1'b1;
    step(4);

    curReq = "R11";
    wr(0, 8'hFF); wr(2, 8'hFE); step(4);
    wr(2, 8'hFF); wr(1, 8'hA5); step(4);

    curReq = "R5";
    wr(2, 0); wr(3, 8'h01); step(4);
    wr(2, 1); step(2);

    curReq = "R2";
    wr(0, 1); wr(1, 8'hA5); wr(3, 8'h01); step(2);
    curReq = "R10";
    wr(1, 8'h3C); wr(0, 0); step(1);
    curReq = "R4";
    ack(0); step(4);

    curReq = "R3";
    wr(0, 0); wr(3, 8'h03); step(4);
    ack(8'h5E); step(4);
    wr(0, 1); wr(3, 8'h03); step(1);
    ack(8'hC7); step(4);

    curReq = "R6";
    pwrGood = 1'b0; wr(3, 8'h01); step(3);
    pwrGood = 1'b1;
    curReq = "R9";
    wr(3, 8'h00); step(2);
    wr(3, 8'h08); step(3);

    curReq = "R7";
    wr(1, 8'h99); wr(3, 8'h01); step(2);
    wr(3, 8'h03); step(5);
    ack(0); step(3);
    wr(3, 8'h08); step(2);

    curReq = "R8";
    wr(3, 8'h03); step(TO + 6);
    curReq = "R9";
    wr(3, 8'h09); step(3);
    curReq = "R8";
    wr(3, 8'h01); step(TO - 2);
    ack(0); step(3);

    curReq = "R4";
    wr(3, 8'h01); step(1); ack(0); step(3);
    for (int w = 2; w <= 8; w++) begin
      wr(0, w & 1); wr(3, (w & 1) ? 8'h03 : 8'h01); step(w - 1);
      ack(w * 17); step(2);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule